// File: doc/BRIEF.md
# Upper-Level Vector Index Maintainer

This block keeps the sparse upper level of a two-level sorted suffix list. The lower level is a linked list of suffix nodes, held in an external RAM. The lower level is cut into contiguous vectors, and each vector is summarised by one upper node. An upper node holds its neighbour links, a pointer to the smallest suffix in its vector, a mask of the symbols that occur in the vector, a member count and a flag that marks the final upper node. A search engine can read a summary and skip a whole vector when the symbol it looks for is absent.

An external inserter links a new lower node into the list (its successor pointer and symbol). It then reports the insertion here: the covering upper node, the new node's address, the node it was placed after, and whether the new node became the vector's smallest member or was placed after the vector's boundary member. The block writes the new node's upper pointer and boundary marker, fixes the old boundary marker, and updates the summary one cycle later. An insertion that would bring a vector to 2×`VEC_MIN` members splits the vector. The block takes a fresh upper node from a free counter, links it in, and walks all members through the lower RAM port. During the walk it rewrites each member's upper pointer and boundary bit and rebuilds both symbol masks exactly.

Top module: `vec_index_maint`

## Requirements
- R1: After reset, `busy` is low. Upper node 0 has count 0, final flag 1 and an empty symbol mask. Every other upper node has final flag 0.
- R2: An insertion is accepted on a clock edge where `ins_valid` is high and `busy` is low. `busy` is high in the next cycle. If no split occurs, one edge later the covering node's count has grown by one and the mask bit of `ins_sym` (bit index equal to the 7-bit symbol value) is set.
- R3: The covering node's smallest-member pointer becomes `ins_node` when `ins_head` is high or when the vector was empty. Otherwise it is unchanged.
- R4: In the cycle after acceptance, the block writes the lower entry at `ins_node` with upper pointer `ins_up` and boundary bit equal to `ins_after_bnd`.
- R5: When `ins_after_bnd` is high and no split occurs, the block writes the lower entry at `ins_pred` with boundary bit 0 in the following cycle, so `busy` lasts two cycles. Otherwise, without a split, `busy` lasts one cycle.
- R6: `ins_valid` raised while `busy` is high is ignored: no lower write to that node and no summary change.
- R7: An insertion reaching a count of 2×`VEC_MIN` splits the vector. The new upper node is the next free index (1 after reset, then 2, …). It is linked after the original: its predecessor is the original, and its successor and final flag are the original's old ones. The original's successor becomes the new node and its final flag is cleared. The old successor's predecessor becomes the new node. Both counts become `VEC_MIN`.
- R8: After a split, the original's mask holds exactly the symbols of the first `VEC_MIN` members in list order, and the new node's mask holds exactly those of the remaining members.
- R9: A split rewrites every member's lower entry. The first `VEC_MIN` members in list order get the original's index and the rest get the new index. The boundary bit is 1 only on member `VEC_MIN` and on the last member. The new node's smallest-member pointer is member `VEC_MIN`+1.
- R10: `busy` stays high for the whole split: 1 + 4×`VEC_MIN` cycles. Each lower read is followed in the next cycle by a write to the same address. No lower access happens while `busy` is low.
- R11: `q_hit` reports combinationally the mask bit of `q_sym` in upper node `q_idx`. `q_count`, `q_lower`, `q_prev`, `q_next` and `q_last` report that node's fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insertion report |
| ins_up | input | UW | Covering upper node |
| ins_node | input | LOW_AW | New lower node address |
| ins_pred | input | LOW_AW | Lower node the new node follows |
| ins_sym | input | SW | Symbol of the new node |
| ins_head | input | 1 | New node precedes the vector's smallest member |
| ins_after_bnd | input | 1 | New node placed after the boundary member |
| busy | output | 1 | Insertion or split in progress |
| low_rd_en | output | 1 | Lower RAM read strobe |
| low_rd_addr | output | LOW_AW | Lower RAM read address |
| low_rd_next | input | LOW_AW | Successor pointer, one cycle after read |
| low_rd_sym | input | SW | Symbol, one cycle after read |
| low_wr_en | output | 1 | Lower RAM write strobe |
| low_wr_addr | output | LOW_AW | Lower RAM write address |
| low_wr_up | output | UW | Upper pointer written |
| low_wr_bnd | output | 1 | Boundary bit written |
| q_idx | input | UW | Queried upper node |
| q_sym | input | SW | Queried symbol |
| q_hit | output | 1 | Symbol present in queried vector |
| q_count | output | CW | Member count |
| q_lower | output | LOW_AW | Smallest member |
| q_prev | output | UW | Predecessor upper node |
| q_next | output | UW | Successor upper node |
| q_last | output | 1 | Final upper node flag |

## Verification
The bench first fills one vector through head and tail insertions, with a repeated symbol and the extreme symbol values 0 and 127. A wrong smallest-pointer rule would leave a stale `q_lower`, and a missing boundary fix would leave two boundary bits in one vector. It then drives the vector to the split point twice. The second split lands between two existing upper nodes, which exposes a design that forgets the old successor's predecessor link or moves the final flag wrongly. The full mask comparison after each split catches a walk that is off by one at the half boundary, since symbols were chosen so that each half has its own. A pulse on `ins_valid` during a split catches a design that lets a command slip into the walk.

// File: rtl/vec_index_maint.sv
module vec_index_maint #(
  parameter int LOW_AW   = 10,
  parameter int UP_NODES = 8,
  parameter int SYMS     = 128,
  parameter int VEC_MIN  = 20,
  localparam int UW      = $clog2(UP_NODES),
  localparam int SW      = $clog2(SYMS),
  localparam int VEC_MAX = 2 * VEC_MIN,
  localparam int CW      = $clog2(VEC_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [UW-1:0]     ins_up,
  input  logic [LOW_AW-1:0] ins_node,
  input  logic [LOW_AW-1:0] ins_pred,
  input  logic [SW-1:0]     ins_sym,
  input  logic              ins_head,
  input  logic              ins_after_bnd,
  output logic              busy,
  output logic              low_rd_en,
  output logic [LOW_AW-1:0] low_rd_addr,
  input  logic [LOW_AW-1:0] low_rd_next,
  input  logic [SW-1:0]     low_rd_sym,
  output logic              low_wr_en,
  output logic [LOW_AW-1:0] low_wr_addr,
  output logic [UW-1:0]     low_wr_up,
  output logic              low_wr_bnd,
  input  logic [UW-1:0]     q_idx,
  input  logic [SW-1:0]     q_sym,
  output logic              q_hit,
  output logic [CW-1:0]     q_count,
  output logic [LOW_AW-1:0] q_lower,
  output logic [UW-1:0]     q_prev,
  output logic [UW-1:0]     q_next,
  output logic              q_last
);

  typedef enum logic [2:0] {S_IDLE, S_UPD, S_BFIX, S_RD, S_WR} st_t;
  st_t st;

  logic [UW-1:0]     u_prev [UP_NODES];
  logic [UW-1:0]     u_next [UP_NODES];
  logic [LOW_AW-1:0] u_low  [UP_NODES];
  logic [SYMS-1:0]   u_flag [UP_NODES];
  logic [CW-1:0]     u_cnt  [UP_NODES];
  logic [UP_NODES-1:0] u_last;

  logic [UW-1:0]     c_up;
  logic [LOW_AW-1:0] c_node, c_pred, cur;
  logic [SW-1:0]     c_sym;
  logic              c_head, c_ab;
  logic [UW:0]       free_ptr;
  logic [UW-1:0]     sp_new;
  logic [CW-1:0]     idx;
  logic [SYMS-1:0]   mask_a, mask_b;

  wire [SYMS-1:0] sym_bit  = SYMS'(1) << c_sym;
  wire [SYMS-1:0] rd_bit   = SYMS'(1) << low_rd_sym;
  wire            has_free = free_ptr < (UW+1)'(UP_NODES);
  wire            do_split = (u_cnt[c_up] == CW'(VEC_MAX - 1)) && has_free;
  wire            second   = idx >= CW'(VEC_MIN);
  wire            last_mem = idx == CW'(VEC_MAX - 1);

  assign busy        = st != S_IDLE;
  assign low_rd_en   = st == S_RD;
  assign low_rd_addr = cur;
  assign low_wr_en   = (st == S_UPD) || (st == S_BFIX) || (st == S_WR);
  assign low_wr_addr = (st == S_UPD) ? c_node : (st == S_BFIX) ? c_pred : cur;
  assign low_wr_up   = (st == S_WR && second) ? sp_new : c_up;
  assign low_wr_bnd  = (st == S_UPD) ? c_ab :
                       (st == S_WR)  ? (idx == CW'(VEC_MIN - 1)) || last_mem : 1'b0;

  assign q_hit   = u_flag[q_idx][q_sym];
  assign q_count = u_cnt[q_idx];
  assign q_lower = u_low[q_idx];
  assign q_prev  = u_prev[q_idx];
  assign q_next  = u_next[q_idx];
  assign q_last  = u_last[q_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      free_ptr <= (UW+1)'(1);
      u_last   <= UP_NODES'(1);
      c_up <= '0; c_node <= '0; c_pred <= '0; c_sym <= '0;
      c_head <= 1'b0; c_ab <= 1'b0;
      sp_new <= '0; cur <= '0; idx <= '0; mask_a <= '0; mask_b <= '0;
      for (int i = 0; i < UP_NODES; i++) begin
        u_prev[i] <= '0; u_next[i] <= '0; u_low[i] <= '0;
        u_flag[i] <= '0; u_cnt[i]  <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (ins_valid) begin
          c_up <= ins_up; c_node <= ins_node; c_pred <= ins_pred;
          c_sym <= ins_sym; c_head <= ins_head; c_ab <= ins_after_bnd;
          st <= S_UPD;
        end
        S_UPD: begin
          if (c_head || u_cnt[c_up] == '0) u_low[c_up] <= c_node;
          if (do_split) begin
            sp_new <= free_ptr[UW-1:0];
            free_ptr <= free_ptr + 1'b1;
            u_prev[free_ptr[UW-1:0]] <= c_up;
            u_next[free_ptr[UW-1:0]] <= u_next[c_up];
            u_last[free_ptr[UW-1:0]] <= u_last[c_up];
            u_next[c_up] <= free_ptr[UW-1:0];
            u_last[c_up] <= 1'b0;
            if (!u_last[c_up]) u_prev[u_next[c_up]] <= free_ptr[UW-1:0];
            cur <= c_head ? c_node : u_low[c_up];
            idx <= '0; mask_a <= '0; mask_b <= '0;
            st <= S_RD;
          end else begin
            u_flag[c_up] <= u_flag[c_up] | sym_bit;
            u_cnt[c_up]  <= u_cnt[c_up] + 1'b1;
            st <= c_ab ? S_BFIX : S_IDLE;
          end
        end
        S_BFIX: st <= S_IDLE;
        S_RD:   st <= S_WR;
        S_WR: begin
          if (second) mask_b <= mask_b | rd_bit;
          else        mask_a <= mask_a | rd_bit;
          if (idx == CW'(VEC_MIN)) u_low[sp_new] <= cur;
          cur <= low_rd_next;
          idx <= idx + 1'b1;
          if (last_mem) begin
            u_flag[c_up]   <= mask_a;
            u_flag[sp_new] <= mask_b | rd_bit;
            u_cnt[c_up]    <= CW'(VEC_MIN);
            u_cnt[sp_new]  <= CW'(VEC_MIN);
            st <= S_IDLE;
          end else begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module vec_index_maint_chk #(
  parameter int LOW_AW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              busy,
  input logic              low_rd_en,
  input logic [LOW_AW-1:0] low_rd_addr,
  input logic              low_wr_en,
  input logic [LOW_AW-1:0] low_wr_addr
);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !busy |=> busy);

  // R4
  accept_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !busy |=> low_wr_en && !low_rd_en);

  // R10
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_rd_en |=> low_wr_en && low_wr_addr == $past(low_rd_addr));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !low_rd_en && !low_wr_en);

endmodule

bind vec_index_maint vec_index_maint_chk #(.LOW_AW(LOW_AW)) u_chk (.*);

// File: tb/sim_vec_index_maint.sv
module sim_vec_index_maint;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       ins_valid = 1'b0, ins_head = 1'b0, ins_after_bnd = 1'b0;
  logic [2:0] ins_up = '0, q_idx = '0, low_wr_up, q_prev, q_next;
  logic [9:0] ins_node = '0, ins_pred = '0, low_rd_addr, low_rd_next, low_wr_addr, q_lower;
  logic [6:0] ins_sym = '0, low_rd_sym, q_sym = '0;
  logic       busy, low_rd_en, low_wr_en, low_wr_bnd, q_hit, q_last;
  logic [5:0] q_count;

  vec_index_maint u0 (.*);

  logic [9:0] lo_next [1024];
  logic [6:0] lo_sym  [1024];
  logic [2:0] lo_up   [1024];
  logic       lo_bnd  [1024];
  logic       seen1000;

  always @(posedge clk) begin
    if (low_rd_en) begin
      low_rd_next <= lo_next[low_rd_addr];
      low_rd_sym  <= lo_sym[low_rd_addr];
    end
    if (!rst_n) seen1000 <= 1'b0;
    else if (low_wr_en) begin
      lo_up[low_wr_addr]  <= low_wr_up;
      lo_bnd[low_wr_addr] <= low_wr_bnd;
      if (low_wr_addr == 10'd1000) seen1000 <= 1'b1;
    end
  end

  int n_tests = 0, n_fail = 0;
  int v0 [64];
  int v0n = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic query(input int node, input int sym);
    q_idx = 3'(node); q_sym = 7'(sym); #1;
  endtask

  task automatic do_ins(input int up, input int node, input int pred, input int sym,
                        input bit head, input bit ab, input bit poke, output int bc);
    @(negedge clk);
    ins_up = 3'(up); ins_node = 10'(node); ins_pred = 10'(pred); ins_sym = 7'(sym);
    ins_head = head; ins_after_bnd = ab; ins_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    ins_valid = 1'b0;
    bc = 0;
    while (busy && bc < 500) begin
      bc++;
      if (poke && bc == 6) begin
        ins_node = 10'd1000; ins_pred = 10'd1000; ins_sym = 7'd5; ins_head = 1'b1; ins_valid = 1'b1;
      end
      if (poke && bc == 9) ins_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic ins_v0(input int node, input int sym, input bit head, input bit poke, output int bc);
    int pred;
    lo_sym[node] = 7'(sym);
    if (head) begin
      lo_next[node] = 10'(v0[0]);
      for (int k = v0n; k > 0; k--) v0[k] = v0[k-1];
      v0[0] = node; v0n++;
      do_ins(0, node, 0, sym, 1'b1, 1'b0, poke, bc);
    end else begin
      pred = (v0n > 0) ? v0[v0n-1] : 1023;
      if (v0n > 0) begin
        lo_next[node] = lo_next[pred];
        lo_next[pred] = 10'(node);
      end else lo_next[node] = 10'd1022;
      v0[v0n] = node; v0n++;
      do_ins(0, node, pred, sym, 1'b0, 1'b1, poke, bc);
    end
  endtask

  localparam int TN = 7;
  localparam int T_NODE [TN] = '{1, 2, 3, 4, 5, 6, 7};
  localparam int T_SYM  [TN] = '{65, 66, 67, 65, 100, 127, 0};
  localparam bit T_HEAD [TN] = '{0, 0, 1, 0, 1, 0, 1};
  localparam int T_LOW  [TN] = '{1, 1, 3, 3, 5, 5, 7};

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int bc, bad, v1 [20];
    bit e;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    chk(busy == 1'b0, "R1", "busy", busy, 0);
    query(0, 65);
    chk(q_count == 0, "R1", "node0 count", q_count, 0);
    chk(q_last == 1'b1, "R1", "node0 last", q_last, 1);
    chk(q_hit == 1'b0, "R1", "node0 hit", q_hit, 0);
    query(1, 0);
    chk(q_last == 1'b0, "R1", "node1 last", q_last, 0);

    for (int i = 0; i < TN; i++) begin
      int pred;
      pred = (v0n > 0) ? v0[v0n-1] : 0;
      ins_v0(T_NODE[i], T_SYM[i], T_HEAD[i], 1'b0, bc);
      chk(bc == (T_HEAD[i] ? 1 : 2), "R5", "busy cycles", bc, T_HEAD[i] ? 1 : 2);
      query(0, T_SYM[i]);
      chk(q_count == 6'(i + 1), "R2", "count", q_count, i + 1);
      chk(q_hit == 1'b1, "R11", "hit", q_hit, 1);
      chk(q_lower == 10'(T_LOW[i]), "R3", "smallest", q_lower, T_LOW[i]);
      chk(lo_up[T_NODE[i]] == 3'd0 && lo_bnd[T_NODE[i]] == !T_HEAD[i], "R4", "new entry bnd",
          lo_bnd[T_NODE[i]], !T_HEAD[i]);
      if (!T_HEAD[i] && i > 0)
        chk(lo_bnd[pred] == 1'b0, "R5", "old boundary", lo_bnd[pred], 0);
    end
    query(0, 66);
    chk(q_hit == 1'b1, "R11", "sym 66 still present", q_hit, 1);
    query(0, 101);
    chk(q_hit == 1'b0, "R11", "sym 101 absent", q_hit, 0);

    for (int n = 8; n <= 39; n++) ins_v0(n, (n <= 20) ? 10 + n % 4 : 50 + n % 4, 1'b0, 1'b0, bc);
    query(0, 0);
    chk(q_count == 6'd39, "R2", "count before split", q_count, 39);
    ins_v0(40, 50, 1'b0, 1'b0, bc);
    chk(bc == 81, "R10", "split busy", bc, 81);

    query(0, 0);
    chk(q_count == 6'd20, "R7", "orig count", q_count, 20);
    chk(q_next == 3'd1 && q_last == 1'b0, "R7", "orig next", q_next, 1);
    chk(q_lower == 10'd7, "R3", "orig smallest", q_lower, 7);
    query(1, 0);
    chk(q_count == 6'd20, "R7", "new count", q_count, 20);
    chk(q_prev == 3'd0 && q_last == 1'b1, "R7", "new prev", q_prev, 0);
    chk(q_lower == 10'd21, "R9", "new smallest", q_lower, 21);

    for (int nd = 0; nd < 2; nd++) begin
      bad = 0;
      for (int s = 0; s < 128; s++) begin
        e = 1'b0;
        for (int k = nd * 20; k < nd * 20 + 20; k++) if (lo_sym[v0[k]] == 7'(s)) e = 1'b1;
        query(nd, s);
        if (q_hit != e) bad++;
      end
      chk(bad == 0, "R8", "mask mismatches", bad, 0);
    end

    bad = 0;
    for (int k = 0; k < 40; k++) begin
      if (lo_up[v0[k]] != 3'((k < 20) ? 0 : 1)) bad++;
      if (lo_bnd[v0[k]] != (k == 19 || k == 39)) bad++;
    end
    chk(bad == 0, "R9", "member entry mismatches", bad, 0);

    for (int k = 0; k < 20; k++) v1[k] = v0[k + 20];
    v0n = 20;
    for (int n = 41; n <= 59; n++) ins_v0(n, 90, 1'b0, 1'b0, bc);
    ins_v0(60, 90, 1'b0, 1'b1, bc);
    chk(bc == 81, "R10", "second split busy", bc, 81);
    chk(seen1000 == 1'b0, "R6", "write to poked node", seen1000, 0);

    query(0, 90);
    chk(q_count == 6'd20 && q_hit == 1'b0, "R6", "orig count", q_count, 20);
    chk(q_next == 3'd2 && q_last == 1'b0, "R7", "orig next", q_next, 2);
    query(2, 90);
    chk(q_count == 6'd20 && q_hit == 1'b1, "R8", "node2 count", q_count, 20);
    chk(q_prev == 3'd0 && q_next == 3'd1, "R7", "node2 next", q_next, 1);
    chk(q_last == 1'b0, "R7", "node2 last", q_last, 0);
    query(2, 5);
    chk(q_hit == 1'b0, "R6", "poked sym", q_hit, 0);
    chk(q_lower == 10'd41, "R9", "node2 smallest", q_lower, 41);
    query(1, 50);
    chk(q_prev == 3'd2 && q_last == 1'b1, "R7", "node1 prev", q_prev, 2);
    chk(q_hit == 1'b1 && q_count == 6'd20, "R8", "node1 kept", q_count, 20);

    bad = 0;
    for (int n = 41; n <= 60; n++) begin
      if (lo_up[n] != 3'd2) bad++;
      if (lo_bnd[n] != (n == 60)) bad++;
    end
    if (lo_bnd[20] != 1'b1 || lo_up[20] != 3'd0) bad++;
    if (lo_up[v1[0]] != 3'd1) bad++;
    chk(bad == 0, "R9", "second split entries", bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule